// File: doc/BRIEF.md
# Packed Multiply-Add Dot-Product Engine

This block computes integer dot products from packed 16-bit operands. Each accepted beat carries two 64-bit words. Each word holds four signed 16-bit elements, and element k sits at bits 16k+15..16k. The block forms the four element-wise products. Depending on the operation code, it then does one of three things: returns adjacent product pairs summed into two 32-bit lanes, returns the upper half of each 32-bit product as four packed 16-bit values, or adds the pair sums into two 40-bit lane accumulators.

An accumulation runs over as many beats as the caller sends. The caller flags the final beat. After that beat the block spends one cycle reducing: it adds the two lane accumulators, shifts the total arithmetically right by a programmable amount for fixed-point scaling, and presents the scalar with a one-cycle done pulse. An eight-element dot product therefore needs only two beats. Input is a valid/ready pair, and output is a done strobe with a 64-bit result that holds until the next result.

Top module: `dotp_engine`

## Requirements
- R1: With operation code 0 or 3, an accepted beat yields result bits 31..0 = a0*b0+a1*b1 and bits 63..32 = a2*b2+a3*b3, each sum taken modulo 2^32. Four elements of -32768 therefore give 0x80000000 in each lane.
- R2: With operation code 1, an accepted beat yields result bits 16k+15..16k = bits 31..16 of the signed product ak*bk, for k = 0..3.
- R3: For codes 0, 1 and 3, done is high in the cycle right after acceptance and the result is valid in that cycle. Ready stays high.
- R4: With code 2, each accepted beat adds its two full, unwrapped 33-bit pair sums into two 40-bit lane accumulators. A beat with inLast low raises no done.
- R5: One cycle after a code-2 beat with inLast high, ready is low and done is low for exactly one cycle. In the following cycle done pulses, and the result is (lane0+lane1) arithmetically shifted right by the inShift value of that last beat, sign-extended to 64 bits.
- R6: clearAcc zeroes both accumulators. If clearAcc coincides with an accepted code-2 beat, that beat's pair sums become the new accumulator contents.
- R7: After reset, done is low, ready is high, the result is zero and the accumulators are zero.
- R8: A cycle without inValid produces no done and leaves the accumulators and the result unchanged.
- R9: In code 2, a pair sum of 2^31 (all elements -32768) accumulates as +2^31 without wrapping.
- R10: Single-beat operations between accumulation beats leave the accumulators unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Beat offered |
| inReady | output | 1 | Beat can be taken |
| inMode | input | 2 | Operation code: 0 pair sums, 1 multiply-high, 2 accumulate, 3 same as 0 |
| inLast | input | 1 | Final accumulation beat |
| inShift | input | 5 | Right-shift amount for the reduction |
| clearAcc | input | 1 | Zero the accumulators |
| inA | input | 64 | Four packed signed 16-bit elements |
| inB | input | 64 | Four packed signed 16-bit elements |
| done | output | 1 | Result valid strobe |
| result | output | 64 | Packed or scalar result |

## Verification
A corrupted product or pair sum appears on result in the cycle after the offending beat, so single-beat patterns, including the -32768 corner, isolate arithmetic faults at once. A wrong accumulator value stays hidden until the next reduction, which is why each accumulation scenario ends in a reduction whose scalar is compared. Interleaved single-beat operations, idle cycles and clear pulses then show whether accumulator state was disturbed. A control fault shows as a missing or extra done pulse, or as ready failing to drop for exactly one cycle after a last beat.

// File: rtl/dotp_pkg.sv
`timescale 1ns/1ps
package dotp_pkg;

  typedef enum logic [1:0] {
    OP_PAIR = 2'd0,
    OP_HIGH = 2'd1,
    OP_ACC  = 2'd2,
    OP_ALT  = 2'd3
  } opCode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadPair;
    logic loadHigh;
    logic accStep;
    logic accClear;
    logic reduce;
  } dpStrobe_t;

endpackage

// File: rtl/dotp_ctrl.sv
`timescale 1ns/1ps
module dotp_ctrl
  import dotp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] inMode,
  input  logic       inLast,
  input  logic       clearAcc,
  output logic       inReady,
  output dpStrobe_t  strobe,
  output logic       done
);

  typedef enum logic {ST_RUN, ST_REDUCE} ctrlState_e;

  ctrlState_e state, stateNext;
  opCode_e    op;
  logic       accept;

  assign op      = opCode_e'(inMode);
  assign inReady = (state == ST_RUN);
  assign accept  = inValid && inReady;

  always_comb begin
    strobe          = '0;
    strobe.loadPair = accept && ((op == OP_PAIR) || (op == OP_ALT));
    strobe.loadHigh = accept && (op == OP_HIGH);
    strobe.accStep  = accept && (op == OP_ACC);
    strobe.accClear = clearAcc;
    strobe.reduce   = (state == ST_REDUCE);
  end

  always_comb begin
    stateNext = ST_RUN;
    if (state == ST_RUN && accept && op == OP_ACC && inLast) begin
      stateNext = ST_REDUCE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_RUN;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobe.loadPair || strobe.loadHigh || strobe.reduce;
    end
  end

endmodule

// File: rtl/dotp_datapath.sv
`timescale 1ns/1ps
module dotp_datapath
  import dotp_pkg::*;
#(
  parameter int ELEM_W   = 16,
  parameter int NUM_ELEM = 4,
  parameter int ACC_W    = 40,
  parameter int SHIFT_W  = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobe_t                  strobe,
  input  logic [ELEM_W*NUM_ELEM-1:0] inA,
  input  logic [ELEM_W*NUM_ELEM-1:0] inB,
  input  logic [SHIFT_W-1:0]         inShift,
  output logic [ELEM_W*NUM_ELEM-1:0] result
);

  localparam int DATA_W   = ELEM_W * NUM_ELEM;
  localparam int PROD_W   = 2 * ELEM_W;
  localparam int NUM_LANE = NUM_ELEM / 2;
  localparam int RED_W    = ACC_W + $clog2(NUM_LANE) + 1;

  logic signed [PROD_W-1:0] prod    [NUM_ELEM];
  logic        [PROD_W:0]   pairSum [NUM_LANE];
  logic        [ACC_W-1:0]  acc     [NUM_LANE];
  logic        [DATA_W-1:0] pairWord;
  logic        [DATA_W-1:0] highWord;
  logic        [SHIFT_W-1:0] shiftReg;
  logic signed [RED_W-1:0]  redSum;
  logic signed [RED_W-1:0]  redShift;
  logic        [DATA_W-1:0] redWord;

  // Element-wise signed products and multiply-high packing
  for (genvar e = 0; e < NUM_ELEM; e++) begin : g_elem
    assign prod[e] = $signed(inA[e*ELEM_W +: ELEM_W]) * $signed(inB[e*ELEM_W +: ELEM_W]);
    assign highWord[e*ELEM_W +: ELEM_W] = prod[e][PROD_W-1:ELEM_W];
  end

  // Adjacent pair folding into lanes, with lane accumulators
  for (genvar l = 0; l < NUM_LANE; l++) begin : g_lane
    assign pairSum[l] = {prod[2*l][PROD_W-1], prod[2*l]}
                      + {prod[2*l+1][PROD_W-1], prod[2*l+1]};
    assign pairWord[l*PROD_W +: PROD_W] = pairSum[l][PROD_W-1:0];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        acc[l] <= '0;
      end else if (strobe.accClear || strobe.accStep) begin
        acc[l] <= (strobe.accClear ? '0 : acc[l])
                + (strobe.accStep
                   ? {{(ACC_W-PROD_W-1){pairSum[l][PROD_W]}}, pairSum[l]}
                   : '0);
      end
    end
  end

  // Final reduction across lanes with scaling shift
  always_comb begin
    redSum = '0;
    for (int l = 0; l < NUM_LANE; l++) begin
      redSum = redSum + {{(RED_W-ACC_W){acc[l][ACC_W-1]}}, acc[l]};
    end
  end

  assign redShift = redSum >>> shiftReg;
  assign redWord  = {{(DATA_W-RED_W){redShift[RED_W-1]}}, redShift};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      result   <= '0;
    end else begin
      if (strobe.accStep) begin
        shiftReg <= inShift;
      end
      if (strobe.loadPair) begin
        result <= pairWord;
      end else if (strobe.loadHigh) begin
        result <= highWord;
      end else if (strobe.reduce) begin
        result <= redWord;
      end
    end
  end

endmodule

// File: rtl/dotp_engine.sv
`timescale 1ns/1ps
module dotp_engine
  import dotp_pkg::*;
#(
  parameter int ELEM_W   = 16,
  parameter int NUM_ELEM = 4,
  parameter int ACC_W    = 40,
  parameter int SHIFT_W  = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  output logic                       inReady,
  input  logic [1:0]                 inMode,
  input  logic                       inLast,
  input  logic [SHIFT_W-1:0]         inShift,
  input  logic                       clearAcc,
  input  logic [ELEM_W*NUM_ELEM-1:0] inA,
  input  logic [ELEM_W*NUM_ELEM-1:0] inB,
  output logic                       done,
  output logic [ELEM_W*NUM_ELEM-1:0] result
);

  dpStrobe_t strobe;

  dotp_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inMode   (inMode),
    .inLast   (inLast),
    .clearAcc (clearAcc),
    .inReady  (inReady),
    .strobe   (strobe),
    .done     (done)
  );

  dotp_datapath #(
    .ELEM_W   (ELEM_W),
    .NUM_ELEM (NUM_ELEM),
    .ACC_W    (ACC_W),
    .SHIFT_W  (SHIFT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inA     (inA),
    .inB     (inB),
    .inShift (inShift),
    .result  (result)
  );

endmodule

// File: rtl/dotp_checker.sv
`timescale 1ns/1ps
module dotp_checker #(
  parameter int ELEM_W   = 16,
  parameter int NUM_ELEM = 4,
  parameter int ACC_W    = 40,
  parameter int SHIFT_W  = 5
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       inValid,
  input logic                       inReady,
  input logic [1:0]                 inMode,
  input logic                       inLast,
  input logic [SHIFT_W-1:0]         inShift,
  input logic                       clearAcc,
  input logic [ELEM_W*NUM_ELEM-1:0] inA,
  input logic [ELEM_W*NUM_ELEM-1:0] inB,
  input logic                       done,
  input logic [ELEM_W*NUM_ELEM-1:0] result
);

  logic                  accept;
  logic [2*ELEM_W-1:0]   expLane0;
  logic [2*ELEM_W-1:0]   expProd0;

  assign accept   = inValid && inReady;
  assign expLane0 = $signed(inA[ELEM_W-1:0]) * $signed(inB[ELEM_W-1:0])
                  + $signed(inA[2*ELEM_W-1:ELEM_W]) * $signed(inB[2*ELEM_W-1:ELEM_W]);
  assign expProd0 = $signed(inA[ELEM_W-1:0]) * $signed(inB[ELEM_W-1:0]);

  assert_pair_lane_R1: assert property (@(posedge clk) disable iff (!rstN)
    accept && (inMode == 2'd0) |=> result[2*ELEM_W-1:0] == $past(expLane0));

  assert_high_lane_R2: assert property (@(posedge clk) disable iff (!rstN)
    accept && (inMode == 2'd1) |=> result[ELEM_W-1:0] == $past(expProd0[2*ELEM_W-1:ELEM_W]));

  assert_single_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    accept && (inMode != 2'd2) |=> done && inReady);

  assert_acc_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    accept && (inMode == 2'd2) && !inLast |=> !done);

  assert_reduce_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    accept && (inMode == 2'd2) && inLast |=> !inReady && !done);

  assert_reduce_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |=> done && inReady);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    inReady && !inValid |=> !done && $stable(result));

endmodule

bind dotp_engine dotp_checker #(
  .ELEM_W   (ELEM_W),
  .NUM_ELEM (NUM_ELEM),
  .ACC_W    (ACC_W),
  .SHIFT_W  (SHIFT_W)
) u_chk (.*);

// File: tb/tb_dotp_engine.sv
`timescale 1ns/1ps
module tb_dotp_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [1:0]  inMode = 2'd0;
  logic        inLast = 1'b0;
  logic [4:0]  inShift = 5'd0;
  logic        clearAcc = 1'b0;
  logic [63:0] inA = '0;
  logic [63:0] inB = '0;
  logic        done;
  logic [63:0] result;

  int nChecks = 0;
  int nFail   = 0;

  always #10 clk = ~clk;

  dotp_engine dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inMode(inMode), .inLast(inLast), .inShift(inShift), .clearAcc(clearAcc),
    .inA(inA), .inB(inB), .done(done), .result(result)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic longint pairFull(logic [63:0] a, logic [63:0] b, int l);
    longint p0 = longint'(shortint'(a[l*32 +: 16])) * longint'(shortint'(b[l*32 +: 16]));
    longint p1 = longint'(shortint'(a[l*32+16 +: 16])) * longint'(shortint'(b[l*32+16 +: 16]));
    return p0 + p1;
  endfunction

  function automatic logic [63:0] pairWordExp(logic [63:0] a, logic [63:0] b);
    logic [63:0] w;
    longint s0 = pairFull(a, b, 0);
    longint s1 = pairFull(a, b, 1);
    w[31:0]  = s0[31:0];
    w[63:32] = s1[31:0];
    return w;
  endfunction

  function automatic logic [63:0] highWordExp(logic [63:0] a, logic [63:0] b);
    logic [63:0] w;
    for (int k = 0; k < 4; k++) begin
      int p = int'(shortint'(a[k*16 +: 16])) * int'(shortint'(b[k*16 +: 16]));
      w[k*16 +: 16] = p[31:16];
    end
    return w;
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  // One beat offered at a negedge; returns one negedge after the accepting edge
  task automatic sendBeat(logic [1:0] mode, logic [63:0] a, logic [63:0] b,
                          logic last, logic [4:0] sh, logic clr);
    inValid = 1'b1; inMode = mode; inA = a; inB = b;
    inLast = last; inShift = sh; clearAcc = clr;
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0; clearAcc = 1'b0;
  endtask

  task automatic clearPulse();
    clearAcc = 1'b1;
    @(negedge clk);
    clearAcc = 1'b0;
  endtask

  // After the last beat: check gap cycle, then the reduced scalar
  task automatic checkReduce(string req, longint model, int sh);
    longint expv = model >>> sh;
    chk({req, " ready low in reduce"}, 64'(inReady), 64'(0));
    chk({req, " no done in reduce"}, 64'(done), 64'(0));
    @(negedge clk);
    chk({req, " done after reduce"}, 64'(done), 64'(1));
    chk({req, " reduced value"}, result, expv);
    chk({req, " ready back"}, 64'(inReady), 64'(1));
  endtask

  task automatic testReset();
    chk("R7 done at reset", 64'(done), 64'(0));
    chk("R7 ready at reset", 64'(inReady), 64'(1));
    chk("R7 result at reset", result, 64'(0));
    sendBeat(2'd2, rnd64(), 64'(0), 1'b1, 5'd0, 1'b0);
    checkReduce("R7 accumulators zero", 0, 0);
  endtask

  task automatic testPair();
    logic [63:0] a, b;
    a = 64'h0004_0003_0002_0001; b = 64'hFFFF_0005_0006_0007;
    sendBeat(2'd0, a, b, 1'b0, 5'd0, 1'b0);
    chk("R1 small values", result, pairWordExp(a, b));
    chk("R3 done pair", 64'(done), 64'(1));
    chk("R3 ready pair", 64'(inReady), 64'(1));
    a = 64'h8000_8000_8000_8000; b = a;
    sendBeat(2'd0, a, b, 1'b0, 5'd0, 1'b0);
    chk("R1 corner wrap", result, 64'h8000_0000_8000_0000);
    for (int i = 0; i < 6; i++) begin
      a = rnd64(); b = rnd64();
      sendBeat((i % 2 == 0) ? 2'd0 : 2'd3, a, b, 1'b0, 5'd0, 1'b0);
      chk("R1 random pair", result, pairWordExp(a, b));
    end
  endtask

  task automatic testHigh();
    logic [63:0] a, b;
    a = 64'h8000_7FFF_8000_1234; b = 64'h8000_7FFF_7FFF_FFFF;
    sendBeat(2'd1, a, b, 1'b0, 5'd0, 1'b0);
    chk("R2 high corners", result, highWordExp(a, b));
    chk("R3 done high", 64'(done), 64'(1));
    for (int i = 0; i < 4; i++) begin
      a = rnd64(); b = rnd64();
      sendBeat(2'd1, a, b, 1'b0, 5'd0, 1'b0);
      chk("R2 random high", result, highWordExp(a, b));
    end
  endtask

  task automatic testAccRun(int n, int sh);
    longint model = 0;
    clearPulse();
    for (int i = 0; i < n; i++) begin
      logic [63:0] a = rnd64();
      logic [63:0] b = rnd64();
      logic last = (i == n - 1);
      sendBeat(2'd2, a, b, last, 5'(sh), 1'b0);
      model += pairFull(a, b, 0) + pairFull(a, b, 1);
      if (!last) chk("R4 no done mid accumulation", 64'(done), 64'(0));
    end
    checkReduce("R5 accumulate and shift", model, sh);
  endtask

  task automatic testAccCorner();
    logic [63:0] m = 64'h8000_8000_8000_8000;
    clearPulse();
    sendBeat(2'd2, m, m, 1'b0, 5'd0, 1'b0);
    sendBeat(2'd2, m, m, 1'b1, 5'd0, 1'b0);
    checkReduce("R9 no lane wrap", 64'h2_0000_0000, 0);
  endtask

  task automatic testInterleave();
    logic [63:0] a, b, p, q;
    longint model;
    a = rnd64(); b = rnd64(); p = rnd64(); q = rnd64();
    clearPulse();
    sendBeat(2'd2, a, b, 1'b0, 5'd2, 1'b0);
    model = pairFull(a, b, 0) + pairFull(a, b, 1);
    sendBeat(2'd0, p, q, 1'b0, 5'd0, 1'b0);
    chk("R10 pair between acc beats", result, pairWordExp(p, q));
    sendBeat(2'd1, q, p, 1'b0, 5'd0, 1'b0);
    chk("R10 high between acc beats", result, highWordExp(q, p));
    sendBeat(2'd2, p, p, 1'b1, 5'd2, 1'b0);
    model += pairFull(p, p, 0) + pairFull(p, p, 1);
    checkReduce("R10 accumulators kept", model, 2);
  endtask

  task automatic testIdle();
    logic [63:0] a, b, held;
    longint model;
    a = rnd64(); b = rnd64();
    clearPulse();
    sendBeat(2'd2, a, b, 1'b0, 5'd1, 1'b0);
    model = pairFull(a, b, 0) + pairFull(a, b, 1);
    held = result;
    inMode = 2'd2; inA = rnd64(); inB = rnd64(); inLast = 1'b1;
    @(negedge clk);
    chk("R8 no done when idle acc", 64'(done), 64'(0));
    inMode = 2'd0; inLast = 1'b0;
    @(negedge clk);
    chk("R8 no done when idle pair", 64'(done), 64'(0));
    chk("R8 result held", result, held);
    sendBeat(2'd2, b, a, 1'b1, 5'd1, 1'b0);
    model += pairFull(b, a, 0) + pairFull(b, a, 1);
    checkReduce("R8 accumulators untouched", model, 1);
  endtask

  task automatic testClearWithBeat();
    logic [63:0] a, b, c, d;
    a = rnd64(); b = rnd64(); c = rnd64(); d = rnd64();
    clearPulse();
    sendBeat(2'd2, a, b, 1'b0, 5'd0, 1'b0);
    sendBeat(2'd2, c, d, 1'b1, 5'd0, 1'b1);
    checkReduce("R6 clear with beat", pairFull(c, d, 0) + pairFull(c, d, 1), 0);
  endtask

  task automatic testNegShift();
    logic [63:0] a = 64'h8000_8000_8000_8000;
    logic [63:0] b = 64'h7FFF_7FFF_7FFF_7FFF;
    longint model = 0;
    clearPulse();
    for (int i = 0; i < 3; i++) begin
      sendBeat(2'd2, a, b, (i == 2), 5'd31, 1'b0);
      model += pairFull(a, b, 0) + pairFull(a, b, 1);
    end
    checkReduce("R5 negative max shift", model, 31);
    clearPulse();
    sendBeat(2'd2, a, b, 1'b1, 5'd7, 1'b0);
    checkReduce("R5 negative shift 7", pairFull(a, b, 0) + pairFull(a, b, 1), 7);
  endtask

  initial begin
    #(200000 * 20);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPair();
    testHigh();
    testAccRun(4, 3);
    testAccRun(1, 0);
    testAccRun(256, 8);
    testAccCorner();
    testInterleave();
    testIdle();
    testClearWithBeat();
    testNegShift();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule